// File: doc/BRIEF.md
# Board Control and Identification Register

A small byte-wide register file that sits on an 8-bit register bus and turns software writes into board-level control lines. It holds three control bits behind a masked-write port, a front-panel hex-display port that first reports a fixed board identification code and then becomes the segment control, and an upper-address register that supplies the high address byte when short-address expansion is on.

Reads and writes are single-cycle strobes. Read data is registered and appears on `rdata_o` the cycle after `rd_i`. The display port starts in an identification phase. The first read of that port after reset returns the code 0x28 and ends the phase. From then on the port's stored byte drives the segment outputs. Writes made during the identification phase are kept, but they only reach the display once the phase ends.

Top module: `board_ctl_reg`

## Requirements
- R1: Address 0 is the masked control port. A write updates data bit n (n = 0..2) only when write-data bit n+4 is 0. If bit n+4 is 1, bit n keeps its value.
- R2: After reset, the first read of address 1 returns 0x28 on `rdata_o` one cycle after the `rd_i` strobe.
- R3: After the identification phase, `seg_o` equals the stored display byte. Bit 7 is the decimal point and bits 6..0 are segments G..A. A 1 lights a segment.
- R4: Writes to address 1 before the first read are stored, but `seg_o` stays 0x00 until that read ends the identification phase.
- R5: Once the identification phase is over, reads of address 1 return the stored display byte.
- R6: Control bit 0 is the active-low expansion enable. `xlat_en_o` is 1 when the bit is 0 and 0 when the bit is 1.
- R7: Address 2 holds the upper-address byte. It drives `xlat_addr_o` the cycle after a write and reads back unchanged.
- R8: Control bit 1 is the active-low programming-voltage control. `vpp_n_o` follows the bit, so writing 0 turns the voltage on.
- R9: Control bit 2 is the DMA direction. `dma_rd_o` is 0 for a write to the floppy controller and 1 for a read from it.
- R10: After reset, `vpp_n_o` = 1, `dma_rd_o` = 0, `xlat_en_o` = 0, `xlat_addr_o` = 0x00 and `seg_o` = 0x00.
- R11: Reserved bits read as 0: control-port bits 7..3 and every bit of address 3. Writes to bit 3 or to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| seg_o | output | 8 | Display decimal point (bit 7) and segments G..A |
| vpp_n_o | output | 1 | Programming voltage on when 0 |
| dma_rd_o | output | 1 | DMA direction: 1 reads from the floppy controller |
| xlat_en_o | output | 1 | Upper-address translation enabled |
| xlat_addr_o | output | 8 | Address bits 31..24 for translated accesses |

## Verification
Some properties are checked on every cycle. A masked control bit stays put under its mask. The display stays blank throughout the identification phase. The phase can never re-enter without a reset. An identification read returns 0x28. A write to the upper-address register reaches its output one cycle later.

Other behaviour only shows up in the bench's directed sequences:
- writes made before the first read appearing once the phase ends;
- the bit order of the segment byte;
- reserved bits and the unused address reading as zero;
- the identification code returning after a second reset.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam int unsigned CTL_W = 3;

  localparam logic [AW-1:0] A_CTL  = 2'd0;
  localparam logic [AW-1:0] A_DISP = 2'd1;
  localparam logic [AW-1:0] A_XLAT = 2'd2;

  localparam logic [DW-1:0] BOARD_ID = 8'h28;

  // control bit positions
  localparam int unsigned B_EXP_DIS = 0;
  localparam int unsigned B_VPP_N   = 1;
  localparam int unsigned B_DMA_RD  = 2;

  localparam logic [CTL_W-1:0] CTL_RST = 3'b011;
endpackage

// File: rtl/bcr_mask_reg.sv
module bcr_mask_reg #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] m_i,
  output logic [W-1:0] q_o
);
  for (genvar n = 0; n < W; n++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[n] <= RST_VAL[n];
      else if (we_i && !m_i[n])   q_o[n] <= d_i[n];
    end
  end
endmodule

// File: rtl/bcr_disp_id.sv
module bcr_disp_id #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] ID_VAL = 8'h28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] rd_val_o,
  output logic [DW-1:0] seg_o,
  output logic          id_phase_o
);
  logic [DW-1:0] seg_q;
  logic          id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
      id_q  <= 1'b1;
    end else begin
      if (we_i) seg_q <= d_i;
      if (re_i) id_q  <= 1'b0;
    end
  end

  assign rd_val_o   = id_q ? ID_VAL : seg_q;
  assign seg_o      = id_q ? '0 : seg_q;
  assign id_phase_o = id_q;
endmodule

// File: rtl/bcr_byte_reg.sv
module bcr_byte_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/board_ctl_reg.sv
module board_ctl_reg
  import bcr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] seg_o,
  output logic          vpp_n_o,
  output logic          dma_rd_o,
  output logic          xlat_en_o,
  output logic [DW-1:0] xlat_addr_o
);
  localparam int unsigned MSK_LO = DW / 2;

  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0]    disp_rd;
  logic [DW-1:0]    rd_mux;
  logic             id_phase;

  bcr_mask_reg #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && addr_i == A_CTL),
    .d_i    (wdata_i[CTL_W-1:0]),
    .m_i    (wdata_i[MSK_LO +: CTL_W]),
    .q_o    (ctl_q)
  );

  bcr_disp_id #(.DW(DW), .ID_VAL(BOARD_ID)) u_disp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_i && addr_i == A_DISP),
    .re_i       (rd_i && addr_i == A_DISP),
    .d_i        (wdata_i),
    .rd_val_o   (disp_rd),
    .seg_o      (seg_o),
    .id_phase_o (id_phase)
  );

  bcr_byte_reg #(.DW(DW)) u_xlat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && addr_i == A_XLAT),
    .d_i    (wdata_i),
    .q_o    (xlat_addr_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_CTL:   rd_mux[CTL_W-1:0] = ctl_q;
      A_DISP:  rd_mux = disp_rd;
      A_XLAT:  rd_mux = xlat_addr_o;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign xlat_en_o = ~ctl_q[B_EXP_DIS];
  assign vpp_n_o   = ctl_q[B_VPP_N];
  assign dma_rd_o  = ctl_q[B_DMA_RD];
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] seg_o,
  input logic          vpp_n_o,
  input logic [DW-1:0] xlat_addr_o,
  input logic          id_phase
);
  p_mask_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTL && wdata_i[4 + B_VPP_N]) |=> $stable(vpp_n_o));

  p_id_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_DISP && id_phase) |=> (rdata_o == BOARD_ID));

  p_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_phase |-> (seg_o == '0));

  p_no_reenter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_phase |=> !id_phase);

  p_xlat_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_XLAT) |=> (xlat_addr_o == $past(wdata_i)));
endmodule

bind board_ctl_reg bcr_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .seg_o       (seg_o),
  .vpp_n_o     (vpp_n_o),
  .xlat_addr_o (xlat_addr_o),
  .id_phase    (id_phase)
);

// File: tb/sim_board_ctl_reg.sv
`timescale 1ns/1ps
module sim_board_ctl_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o, seg_o, xlat_addr_o;
  logic       vpp_n_o, dma_rd_o, xlat_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  board_ctl_reg u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10 vpp_n", {7'd0, vpp_n_o}, 8'h01);
    chk("R10 dma_rd", {7'd0, dma_rd_o}, 8'h00);
    chk("R10 xlat_en", {7'd0, xlat_en_o}, 8'h00);
    chk("R10 xlat_addr", xlat_addr_o, 8'h00);
    chk("R10 seg", seg_o, 8'h00);
  endtask

  task automatic t_display();
    logic [7:0] d;
    wr(2'd1, 8'hA5);
    chk("R4 blank before id read", seg_o, 8'h00);
    rd(2'd1, d);
    chk("R2 id code", d, 8'h28);
    chk("R4 stored shown after id", seg_o, 8'hA5);
    rd(2'd1, d);
    chk("R5 readback", d, 8'hA5);
    wr(2'd1, 8'h80);
    chk("R3 decimal point bit7", seg_o, 8'h80);
    wr(2'd1, 8'h01);
    chk("R3 segment A bit0", seg_o, 8'h01);
  endtask

  task automatic t_ctl();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    chk("R6 expansion enabled", {7'd0, xlat_en_o}, 8'h01);
    chk("R8 vpp on", {7'd0, vpp_n_o}, 8'h00);
    chk("R9 dma write dir", {7'd0, dma_rd_o}, 8'h00);
    wr(2'd0, 8'h17);
    chk("R1 bit0 masked", {7'd0, xlat_en_o}, 8'h01);
    chk("R8 vpp off", {7'd0, vpp_n_o}, 8'h01);
    chk("R9 dma read dir", {7'd0, dma_rd_o}, 8'h01);
    rd(2'd0, d);
    chk("R1 readback", d, 8'h06);
    wr(2'd0, 8'h70);
    rd(2'd0, d);
    chk("R1 all masked no change", d, 8'h06);
    wr(2'd0, 8'h0F);
    rd(2'd0, d);
    chk("R11 bit3 and high nibble read 0", d, 8'h07);
    chk("R6 expansion disabled", {7'd0, xlat_en_o}, 8'h00);
  endtask

  task automatic t_xlat();
    logic [7:0] d;
    wr(2'd2, 8'hC3);
    chk("R7 xlat output", xlat_addr_o, 8'hC3);
    rd(2'd2, d);
    chk("R7 xlat readback", d, 8'hC3);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(2'd3, 8'hFF);
    rd(2'd3, d);
    chk("R11 unused reads 0", d, 8'h00);
    chk("R11 xlat untouched", xlat_addr_o, 8'hC3);
    chk("R11 seg untouched", seg_o, 8'h01);
    rd(2'd0, d);
    chk("R11 ctl untouched", d, 8'h07);
  endtask

  task automatic t_rereset();
    logic [7:0] d;
    do_reset();
    t_reset();
    rd(2'd1, d);
    chk("R2 id after second reset", d, 8'h28);
    chk("R3 seg after reset cleared", seg_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_display();
    t_ctl();
    t_xlat();
    t_unused();
    t_rereset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule